// File: doc/BRIEF.md
# Bus Machine-Cycle Sequencer with Refresh Counter

This block turns a request for one bus transaction into the T-state sequence of active-low strobes that an 8-bit processor bus needs. One clock is one T-state. Six transaction kinds are supported: opcode fetch, memory read, memory write, I/O read, I/O write and interrupt acknowledge. The core logic presents a kind, an address and, for writes, a data byte. The sequencer then drives the strobes and the address bus. It raises a capture strobe in the T-state whose closing edge should latch read data, and it pulses a done flag in the final T-state.

Slow devices stretch a transaction by holding the wait input low. I/O and interrupt-acknowledge transactions also get a fixed number of extra wait states without being asked. The block contains the 8-bit refresh register and the interrupt vector register. The last two T-states of every opcode fetch are used as a DRAM refresh slot. In that slot the vector register drives the upper address byte, the refresh register drives the lower byte, and the refresh counter then advances.

Top module: `zbus_cycle_seq`

## Requirements
- R1: While reset is low, and once it has been released, all six strobes are high, done, capture and data-enable are low, and the address bus is 0. Reset also clears the refresh and vector registers.
- R2: A fetch with no waits lasts 4 T-states. In T1 and T2, fetch (m1_n), memory request and read are low and the address bus shows the request address. Capture is high in T2. In T3 and T4, refresh and memory request are low, read and m1_n are high, and the address bus shows {vector, refresh}. Done is high in T4.
- R3: Each completed fetch adds 1 modulo 128 to refresh bits 6:0 and leaves bit 7 unchanged. Other transaction kinds leave the register unchanged.
- R4: A refresh load writes all 8 bits of the refresh register and a vector load writes the vector register. Both take effect at the next clock edge.
- R5: A memory read lasts 3 T-states. Memory request and read are low in all three. Capture and done are high in T3.
- R6: A memory write lasts 3 T-states. Memory request and data-enable are active in all three, with the write data on dout. The write strobe is low from T2 through T3. Done is high in T3.
- R7: An I/O read (kind 3) or write (kind 4) always gets exactly one automatic wait state, so it lasts 4 T-states with no external waits. I/O request and read or write are low in every T-state except T1. A read raises capture in T3. Done is high in the last T-state.
- R8: An interrupt acknowledge (kind 5) always gets two automatic wait states, so it lasts 5 T-states. m1_n is low until the state before T3. I/O request is low only in wait states. Read and write stay high. Capture is high in the last wait state, and done is high in T3.
- R9: The wait input is sampled at the end of T2, or at the end of the last automatic wait state if there is one, and again at the end of every further wait state. Each low sample adds one wait state in which the current strobes are held.
- R10: A request is accepted only when the sequencer is idle and the kind is 0 to 5 (0 fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write, 5 interrupt acknowledge). A request that arrives while a transaction is running, or that carries kind 6 or 7, changes no output.
- R11: Read and write are never low together, and memory request and I/O request are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | T-state clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| req_vld | input | 1 | Request a transaction in this cycle |
| req_kind | input | 3 | Transaction kind, 0 to 5 |
| req_addr | input | 16 | Transaction address |
| req_wdata | input | 8 | Write data for memory and I/O writes |
| wait_n | input | 1 | Active-low stretch request from the addressed device |
| r_load | input | 1 | Load the refresh register from reg_wdata |
| i_load | input | 1 | Load the vector register from reg_wdata |
| reg_wdata | input | 8 | Value for refresh or vector register loads |
| m1_n | output | 1 | Low in the first phase of fetch and interrupt acknowledge |
| mreq_n | output | 1 | Memory request |
| iorq_n | output | 1 | I/O request |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe |
| rfsh_n | output | 1 | Refresh slot marker |
| addr | output | 16 | Address bus |
| dout | output | 8 | Write data |
| dout_en | output | 1 | Write data is valid and should be driven |
| rd_latch | output | 1 | Read data should be captured at the end of this T-state |
| cyc_done | output | 1 | Last T-state of the transaction |

## Verification
The assertions check on every clock the properties that hold state by state. They cover strobe exclusivity, the refresh slot appearing only with memory request and without m1_n, the fetch tail following T3, the forced wait after T2 in I/O transactions, and the hold-or-release response to the wait input. They also check that the top refresh bit is preserved, that the refresh counter steps by one or holds, and that the vector register holds between loads. Only the bench scenarios can show the full per-kind waveforms and the exact number of T-states with and without external waits. The same applies to the refresh address seen on the bus after a load, wrap-around of the 7-bit count, and the rejection of requests that arrive while busy or carry an invalid kind.

// File: rtl/zbs_pkg.sv
package zbs_pkg;

  typedef enum logic [2:0] {
    K_FETCH = 3'd0,
    K_MEMRD = 3'd1,
    K_MEMWR = 3'd2,
    K_IORD  = 3'd3,
    K_IOWR  = 3'd4,
    K_IACK  = 3'd5
  } kind_e;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_TW   = 3'd3,
    TS_T3   = 3'd4,
    TS_T4   = 3'd5
  } tstate_e;

  // active-high internal view of the bus strobes
  typedef struct packed {
    logic m1;
    logic mreq;
    logic iorq;
    logic rd;
    logic wr;
    logic rfsh;
    logic doe;
    logic cap;
    logic done;
  } strobe_t;

endpackage

// File: rtl/zbs_rst_sync.sv
module zbs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
    end else begin
      sh_q <= {sh_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sh_q[STAGES-1];

endmodule

// File: rtl/zbs_tstate_fsm.sv
module zbs_tstate_fsm
  import zbs_pkg::*;
#(
  parameter int IO_WAITS   = 1,
  parameter int IACK_WAITS = 2,
  parameter int AUTO_W     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_vld,
  input  logic [2:0] req_kind,
  input  logic       wait_n,
  output tstate_e    state_o,
  output kind_e      kind_o,
  output logic       auto_zero_o,
  output logic       accept_o
);

  tstate_e           state_q, state_d;
  kind_e             kind_q;
  logic [AUTO_W-1:0] auto_q, auto_d;
  logic              kind_ok;

  function automatic logic [AUTO_W-1:0] auto_for(input kind_e k);
    case (k)
      K_IORD, K_IOWR: return AUTO_W'(IO_WAITS);
      K_IACK:         return AUTO_W'(IACK_WAITS);
      default:        return '0;
    endcase
  endfunction

  assign kind_ok  = (req_kind <= 3'(K_IACK));
  assign accept_o = (state_q == TS_IDLE) && req_vld && kind_ok;

  always_comb begin
    state_d = state_q;
    auto_d  = auto_q;
    case (state_q)
      TS_IDLE: begin
        if (accept_o) state_d = TS_T1;
      end
      TS_T1: begin
        state_d = TS_T2;
        auto_d  = auto_for(kind_q);
      end
      TS_T2, TS_TW: begin
        if (auto_q != '0) begin
          state_d = TS_TW;
          auto_d  = auto_q - AUTO_W'(1);
        end else if (!wait_n) begin
          state_d = TS_TW;
        end else begin
          state_d = TS_T3;
        end
      end
      TS_T3: begin
        state_d = (kind_q == K_FETCH) ? TS_T4 : TS_IDLE;
      end
      default: begin
        state_d = TS_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TS_IDLE;
      auto_q  <= '0;
    end else begin
      state_q <= state_d;
      auto_q  <= auto_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= K_FETCH;
    end else if (accept_o) begin
      kind_q <= kind_e'(req_kind);
    end
  end

  assign state_o     = state_q;
  assign kind_o      = kind_q;
  assign auto_zero_o = (auto_q == '0);

  AST_FETCH_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TS_T3 && kind_q == K_FETCH) |=> (state_q == TS_T4)); // R2

  AST_IO_AUTOWAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (IO_WAITS != 0 && state_q == TS_T2 && (kind_q == K_IORD || kind_q == K_IOWR))
      |=> (state_q == TS_TW)); // R7

  AST_IACK_AUTOWAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (IACK_WAITS != 0 && state_q == TS_T2 && kind_q == K_IACK) |=> (state_q == TS_TW)); // R8

  AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == TS_T2 || state_q == TS_TW) && auto_q == '0 && !wait_n)
      |=> (state_q == TS_TW)); // R9

  AST_WAIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == TS_T2 || state_q == TS_TW) && auto_q == '0 && wait_n)
      |=> (state_q == TS_T3)); // R9

  AST_KIND_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != TS_IDLE) |=> $stable(kind_q)); // R10

endmodule

// File: rtl/zbs_strobe_dec.sv
module zbs_strobe_dec
  import zbs_pkg::*;
(
  input  tstate_e state,
  input  kind_e   kind,
  input  logic    auto_zero,
  input  logic    wait_n,
  output strobe_t strb
);

  logic active;
  logic first_ph;
  logic past_t1;
  logic leaving;
  logic is_t3;

  assign active   = (state != TS_IDLE);
  assign first_ph = (state == TS_T1) || (state == TS_T2) || (state == TS_TW);
  assign past_t1  = active && (state != TS_T1);
  assign is_t3    = (state == TS_T3);
  assign leaving  = ((state == TS_T2) || (state == TS_TW)) && auto_zero && wait_n;

  always_comb begin
    strb = '0;
    case (kind)
      K_FETCH: begin
        strb.m1   = first_ph;
        strb.rd   = first_ph;
        strb.mreq = active;
        strb.rfsh = is_t3 || (state == TS_T4);
        strb.cap  = leaving;
        strb.done = (state == TS_T4);
      end
      K_MEMRD: begin
        strb.mreq = active;
        strb.rd   = active;
        strb.cap  = is_t3;
        strb.done = is_t3;
      end
      K_MEMWR: begin
        strb.mreq = active;
        strb.wr   = past_t1;
        strb.doe  = active;
        strb.done = is_t3;
      end
      K_IORD: begin
        strb.iorq = past_t1;
        strb.rd   = past_t1;
        strb.cap  = is_t3;
        strb.done = is_t3;
      end
      K_IOWR: begin
        strb.iorq = past_t1;
        strb.wr   = past_t1;
        strb.doe  = active;
        strb.done = is_t3;
      end
      K_IACK: begin
        strb.m1   = first_ph;
        strb.iorq = (state == TS_TW);
        strb.cap  = leaving;
        strb.done = is_t3;
      end
      default: begin
        strb = '0;
      end
    endcase
  end

endmodule

// File: rtl/zbs_refresh.sv
module zbs_refresh #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              r_load,
  input  logic              i_load,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] r_o,
  output logic [DATA_W-1:0] i_o
);

  logic [DATA_W-1:0] r_q, r_d;
  logic [DATA_W-1:0] i_q;
  logic              r_en;

  assign r_en = r_load || inc;

  always_comb begin
    r_d = r_q;
    if (r_load) begin
      r_d = wdata;
    end else if (inc) begin
      r_d = {r_q[DATA_W-1:CNT_W], r_q[CNT_W-1:0] + CNT_W'(1)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q <= '0;
    end else if (r_en) begin
      r_q <= r_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_q <= '0;
    end else if (i_load) begin
      i_q <= wdata;
    end
  end

  assign r_o = r_q;
  assign i_o = i_q;

  AST_R_TOP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !r_load |=> (r_q[DATA_W-1:CNT_W] == $past(r_q[DATA_W-1:CNT_W]))); // R3

  AST_R_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !r_load) |=> (r_q[CNT_W-1:0] == $past(r_q[CNT_W-1:0]) + CNT_W'(1))); // R3

  AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !r_load) |=> $stable(r_q)); // R3

  AST_R_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    r_load |=> (r_q == $past(wdata))); // R4

  AST_I_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !i_load |=> $stable(i_q)); // R4

endmodule

// File: rtl/zbus_cycle_seq.sv
module zbus_cycle_seq
  import zbs_pkg::*;
#(
  parameter int  DATA_W     = 8,
  parameter int  RCNT_W     = 7,
  parameter int  IO_WAITS   = 1,
  parameter int  IACK_WAITS = 2,
  parameter int  RST_STAGES = 2,
  localparam int ADDR_W     = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              wait_n,
  input  logic              r_load,
  input  logic              i_load,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              m1_n,
  output logic              mreq_n,
  output logic              iorq_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              rfsh_n,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              rd_latch,
  output logic              cyc_done
);

  localparam int AUTO_MAX = (IO_WAITS > IACK_WAITS) ? IO_WAITS : IACK_WAITS;
  localparam int AUTO_W   = $clog2(AUTO_MAX + 2);

  logic              rst_sync_n;
  tstate_e           state;
  kind_e             kind;
  logic              auto_zero;
  logic              accept;
  strobe_t           strb;
  logic              r_inc;
  logic [DATA_W-1:0] r_val, i_val;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  zbs_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  zbs_tstate_fsm #(
    .IO_WAITS   (IO_WAITS),
    .IACK_WAITS (IACK_WAITS),
    .AUTO_W     (AUTO_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .req_vld     (req_vld),
    .req_kind    (req_kind),
    .wait_n      (wait_n),
    .state_o     (state),
    .kind_o      (kind),
    .auto_zero_o (auto_zero),
    .accept_o    (accept)
  );

  zbs_strobe_dec u_dec (
    .state     (state),
    .kind      (kind),
    .auto_zero (auto_zero),
    .wait_n    (wait_n),
    .strb      (strb)
  );

  assign r_inc = strb.done && (kind == K_FETCH);

  zbs_refresh #(.DATA_W(DATA_W), .CNT_W(RCNT_W)) u_rfsh (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .inc    (r_inc),
    .r_load (r_load),
    .i_load (i_load),
    .wdata  (reg_wdata),
    .r_o    (r_val),
    .i_o    (i_val)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign addr     = strb.rfsh ? {i_val, r_val} : addr_q;
  assign dout     = wdata_q;
  assign dout_en  = strb.doe;
  assign rd_latch = strb.cap;
  assign cyc_done = strb.done;
  assign m1_n     = ~strb.m1;
  assign mreq_n   = ~strb.mreq;
  assign iorq_n   = ~strb.iorq;
  assign rd_n     = ~strb.rd;
  assign wr_n     = ~strb.wr;
  assign rfsh_n   = ~strb.rfsh;

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(!rd_n && !wr_n)); // R11

  AST_MREQ_IORQ_EXCL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(!mreq_n && !iorq_n)); // R11

  AST_RFSH_QUAL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rfsh_n |-> (!mreq_n && m1_n && rd_n)); // R2

  AST_IACK_NO_DATA_STROBE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!iorq_n && !m1_n) |-> (rd_n && wr_n)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cyc_done |=> (!cyc_done && m1_n && mreq_n && iorq_n)); // R10

endmodule

// File: tb/zbus_cycle_seq_test.sv
module zbus_cycle_seq_test;

  logic        clk;
  logic        rst_n;
  logic        req_vld;
  logic [2:0]  req_kind;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        wait_n;
  logic        r_load;
  logic        i_load;
  logic [7:0]  reg_wdata;
  logic        m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n;
  logic [15:0] addr;
  logic [7:0]  dout;
  logic        dout_en, rd_latch, cyc_done;

  int   total = 0;
  int   bad   = 0;
  logic [7:0]  r_m;
  logic [7:0]  i_m;
  logic [15:0] last_a;

  zbus_cycle_seq uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_vld   (req_vld),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .wait_n    (wait_n),
    .r_load    (r_load),
    .i_load    (i_load),
    .reg_wdata (reg_wdata),
    .m1_n      (m1_n),
    .mreq_n    (mreq_n),
    .iorq_n    (iorq_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .rfsh_n    (rfsh_n),
    .addr      (addr),
    .dout      (dout),
    .dout_en   (dout_en),
    .rd_latch  (rd_latch),
    .cyc_done  (cyc_done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // expected vector order: m1 mreq iorq rd wr rfsh doe cap done (active high)
  task automatic chk(input string rq, input logic [8:0] es, input logic [15:0] ea,
                     input bit cd, input logic [7:0] ed);
    logic [8:0] act;
    act = {~m1_n, ~mreq_n, ~iorq_n, ~rd_n, ~wr_n, ~rfsh_n, dout_en, rd_latch, cyc_done};
    total++;
    if (act !== es || addr !== ea || (cd && dout !== ed)) begin
      bad++;
      $display("FAIL %s: strobes=%b addr=%h dout=%h expected strobes=%b addr=%h dout=%h",
               rq, act, addr, dout, es, ea, ed);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    r_m = 8'h00; i_m = 8'h00; last_a = 16'h0000;
    repeat (4) begin
      @(negedge clk);
      #1 chk("R1", 9'b0, 16'h0000, 1'b0, 8'h00);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1 chk("R1", 9'b0, 16'h0000, 1'b0, 8'h00);
  endtask

  task automatic load_regs(input bit do_r, input bit do_i, input logic [7:0] v);
    @(negedge clk);
    r_load = do_r; i_load = do_i; reg_wdata = v;
    @(negedge clk);
    r_load = 1'b0; i_load = 1'b0;
    if (do_r) r_m = v;
    if (do_i) i_m = v;
  endtask

  // run one transaction and compare every T-state against the model
  task automatic run_cyc(input string rq, input int kind, input logic [15:0] a,
                         input logic [7:0] wd, input int ext, input bit intrude);
    int autos, n, pre_end;
    bit pre, last;
    logic m1, mreq, iorq, rd, wr, rf, doe, cap, dn;
    logic [15:0] ea;
    autos   = (kind == 3 || kind == 4) ? 1 : (kind == 5) ? 2 : 0;
    n       = ((kind == 0) ? 4 : 3) + autos + ext;
    pre_end = 2 + autos + ext;
    @(negedge clk);
    req_vld = 1'b1; req_kind = 3'(kind); req_addr = a; req_wdata = wd;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (intrude && k == 1) begin
        req_vld = 1'b1; req_kind = 3'd2; req_addr = ~a; req_wdata = ~wd;
      end else begin
        req_vld = 1'b0;
      end
      wait_n = !((k >= 1 + autos) && (k <= autos + ext));
      pre  = (k < pre_end);
      last = (k == n - 1);
      m1 = 0; mreq = 0; iorq = 0; rd = 0; wr = 0; rf = 0; doe = 0; cap = 0; dn = 0;
      ea = a;
      case (kind)
        0: begin
          m1 = pre; rd = pre; mreq = 1; rf = !pre;
          cap = (k == pre_end - 1); dn = last;
          if (!pre) ea = {i_m, r_m};
        end
        1: begin mreq = 1; rd = 1; cap = last; dn = last; end
        2: begin mreq = 1; wr = (k >= 1); doe = 1; dn = last; end
        3: begin iorq = (k >= 1); rd = (k >= 1); cap = last; dn = last; end
        4: begin iorq = (k >= 1); wr = (k >= 1); doe = 1; dn = last; end
        default: begin
          m1 = pre; iorq = (k >= 2) && pre; cap = (k == pre_end - 1); dn = last;
        end
      endcase
      #1 chk(rq, {m1, mreq, iorq, rd, wr, rf, doe, cap, dn}, ea, doe, wd);
    end
    @(negedge clk);
    req_vld = 1'b0; wait_n = 1'b1;
    last_a = a;
    if (kind == 0) r_m = {r_m[7], r_m[6:0] + 7'd1};
    #1 chk(rq, 9'b0, last_a, 1'b0, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b1; req_vld = 1'b0; req_kind = 3'd0; req_addr = 16'h0; req_wdata = 8'h0;
    wait_n = 1'b1; r_load = 1'b0; i_load = 1'b0; reg_wdata = 8'h0;
    r_m = 8'h00; i_m = 8'h00; last_a = 16'h0;

    do_reset();                                     // R1
    run_cyc("R2", 0, 16'h1234, 8'h00, 0, 1'b0);     // fetch, refresh addr 0000
    run_cyc("R2 R9", 0, 16'h2001, 8'h00, 2, 1'b0);  // fetch stretched by two waits
    run_cyc("R5/R11", 1, 16'h8000, 8'h00, 0, 1'b0);
    run_cyc("R5 R9", 1, 16'h8001, 8'h00, 1, 1'b0);
    run_cyc("R6/R11", 2, 16'h4321, 8'hA5, 0, 1'b0);
    run_cyc("R6 R9", 2, 16'h4322, 8'h5A, 3, 1'b0);
    run_cyc("R7", 3, 16'h00FE, 8'h00, 0, 1'b0);
    run_cyc("R7 R9", 4, 16'h00FD, 8'h3C, 1, 1'b0);
    run_cyc("R8", 5, 16'h0038, 8'h00, 0, 1'b0);
    run_cyc("R8 R9", 5, 16'h0039, 8'h00, 2, 1'b0);
    run_cyc("R10", 1, 16'h6000, 8'h00, 0, 1'b1);    // request while busy ignored

    // R10: kind 6 in idle is ignored
    @(negedge clk);
    req_vld = 1'b1; req_kind = 3'd6; req_addr = 16'hBEEF;
    @(negedge clk);
    req_vld = 1'b0;
    #1 chk("R10", 9'b0, last_a, 1'b0, 8'h00);
    @(negedge clk);
    #1 chk("R10", 9'b0, last_a, 1'b0, 8'h00);

    // R4 and R3: load, then watch refresh address wrap while bit 7 stays
    load_regs(1'b1, 1'b0, 8'hFF);
    load_regs(1'b0, 1'b1, 8'h3A);
    run_cyc("R4", 0, 16'h0100, 8'h00, 0, 1'b0);     // refresh 3AFF
    run_cyc("R3", 0, 16'h0101, 8'h00, 0, 1'b0);     // refresh 3A80
    run_cyc("R3", 1, 16'h0102, 8'h00, 0, 1'b0);     // no increment
    run_cyc("R3", 4, 16'h0010, 8'h77, 0, 1'b0);     // no increment
    run_cyc("R3", 0, 16'h0103, 8'h00, 0, 1'b0);     // refresh 3A81
    load_regs(1'b1, 1'b0, 8'h7F);
    run_cyc("R3", 0, 16'h0104, 8'h00, 0, 1'b0);     // refresh 3A7F
    run_cyc("R3", 0, 16'h0105, 8'h00, 0, 1'b0);     // refresh 3A00

    // R1: reset clears refresh and vector registers
    load_regs(1'b1, 1'b1, 8'hC5);
    do_reset();
    run_cyc("R1", 0, 16'h0200, 8'h00, 0, 1'b0);     // refresh 0000

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule